// File: doc/BRIEF.md
# Serial Management Target Responder

This block is the target end of a two-wire serial management link, as found on the management side of an Ethernet PHY. The link master toggles a management clock and drives a data bit that it qualifies with its own output-enable. The responder watches both lines on its system clock. It locks on to a sync pattern of 32 one bits, then decodes a 16-bit header and either captures 16 write bits into a bank of 32 registers or shifts 16 read bits back on a single return line.

The management inputs must already be synchronous to `clk_i`. A rising edge of the management clock is recognised on the system clock edge where the clock is seen high after being seen low on the edge before. The bank holds two identifier registers that keep fixed values. The PHY address field is decoded but not compared, so the responder answers every address.

Top module: `mgmt_resp`

## Requirements
- R1: After reset the return line is 0, every register reads 0 except register 2, which reads 0x0022, and register 3, which reads 0x161A.
- R2: Line bits are taken only on rising edges of the management clock, and a bit counts as 1 only when data-out and output-enable are both high. A sync sent with output-enable low is not recognised.
- R3: Sampled bits enter the low end of a 32-bit shift register. When that register holds all ones, a frame is armed with 32 bits to go, and one bit is used up per rising edge. A run of only 31 ones arms nothing, so the frame that follows has no effect. A longer run of ones still arms the frame.
- R4: When 16 bits remain, the last 16 sampled bits form the header: start [15:14], opcode [13:12], PHY address [11:7], register [6:2] and turnaround [1:0]. Start 01, opcode 01 and turnaround 10 accept a write. The 16 bits that follow, MSB first, are stored in the addressed register on the last of them.
- R5: Start 01, opcode 10 and turnaround bit 0 equal to 0 accept a read. On each of the 16 rising edges after the header, the return line takes the next bit of the addressed register, MSB first. It changes on the same system clock edge that detects the rising edge.
- R6: Any other header aborts the frame. No register changes and the return line does not move.
- R7: Writes to registers 2 and 3 are accepted on the line but leave their values unchanged.
- R8: The PHY address field does not affect whether a frame is accepted or which register it uses.
- R9: Outside the 16-bit data phase of an accepted read, the return line keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mgmt_clk_i | input | 1 | Management clock from the master, synchronous to clk_i |
| mgmt_dout_i | input | 1 | Data bit driven by the master |
| mgmt_oe_i | input | 1 | Master output-enable qualifying mgmt_dout_i |
| mgmt_din_o | output | 1 | Bit returned to the master |

## Verification
Each read bit is due one system clock after the system clock edge on which the bench raises the management clock. The bench raises that clock at a falling system clock edge and samples the return line at the next falling edge, which is half a cycle after the updating edge. Writes cannot be seen on the line directly, so each one is checked by a later read through the same serial protocol. Header-decode outcomes and the hold behaviour are checked by comparing every sample in a frame against the line value captured before that frame started.

// File: rtl/mgmt_resp_pkg.sv
package mgmt_resp_pkg;
  localparam int HDR_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic [1:0] start;
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] regad;
    logic [1:0] ta;
  } hdr_t;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WR      = 2'b01;
  localparam logic [1:0] OP_RD      = 2'b10;
  localparam logic [1:0] TA_WR      = 2'b10;
endpackage

// File: rtl/mgmt_edge.sv
module mgmt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mgmt_clk_i,
  input  logic mgmt_dout_i,
  input  logic mgmt_oe_i,
  output logic rise_o,
  output logic bit_o
);
  logic clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else         clk_q <= mgmt_clk_i;
  end

  assign rise_o = mgmt_clk_i & ~clk_q;
  assign bit_o  = mgmt_dout_i & mgmt_oe_i;
endmodule

// File: rtl/mgmt_framer.sv
module mgmt_framer import mgmt_resp_pkg::*; #(
  parameter int SYNC_LEN = 32,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 5,
  localparam int CNT_W   = $clog2(SYNC_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              din_o,
  output logic              live_o,
  output logic [CNT_W-1:0]  cnt_o,
  output xfer_state_e       state_o
);
  logic [SYNC_LEN-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]    cnt_q, cnt_eff;
  logic                live_q, live_eff, sync;
  xfer_state_e         state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [REG_W-1:0]    dout_q;
  logic                din_q;
  hdr_t                hdr;
  logic                at_hdr, in_data, at_end, wr_ok, rd_ok;

  assign sh_n     = {sh_q[SYNC_LEN-2:0], bit_i};
  assign sync     = &sh_n;
  assign cnt_eff  = sync ? CNT_W'(SYNC_LEN) : cnt_q;
  assign live_eff = sync | live_q;
  assign hdr      = hdr_t'(sh_n[HDR_W-1:0]);

  assign at_hdr  = live_eff && (cnt_eff == CNT_W'(HDR_W));
  assign in_data = live_eff && (cnt_eff <  CNT_W'(REG_W));
  assign at_end  = live_eff && (cnt_eff == '0) && (state_q != ST_IDLE);

  assign wr_ok = (hdr.start == START_CODE) && (hdr.op == OP_WR) && (hdr.ta == TA_WR);
  assign rd_ok = (hdr.start == START_CODE) && (hdr.op == OP_RD) && !hdr.ta[0];

  assign rd_addr_o = ADDR_W'(hdr.regad);
  assign wr_en_o   = rise_i && at_end && (state_q == ST_WRITE);
  assign wr_addr_o = addr_q;
  assign wr_data_o = sh_n[REG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      live_q  <= 1'b0;
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dout_q  <= '0;
      din_q   <= 1'b0;
    end else if (rise_i) begin
      sh_q <= sh_n;
      if (at_hdr) begin
        if (wr_ok)      state_q <= ST_WRITE;
        else if (rd_ok) state_q <= ST_READ;
        else            state_q <= ST_IDLE;
        if (wr_ok || rd_ok) addr_q <= ADDR_W'(hdr.regad);
        if (rd_ok)          dout_q <= rd_data_i;
      end
      if (in_data && state_q == ST_READ) begin
        din_q  <= dout_q[REG_W-1];
        dout_q <= {dout_q[REG_W-2:0], 1'b0};
      end
      if (at_end) state_q <= ST_IDLE;
      if (live_eff) begin
        if (cnt_eff == '0) begin
          live_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          live_q <= 1'b1;
          cnt_q  <= cnt_eff - 1'b1;
        end
      end
    end
  end

  assign din_o   = din_q;
  assign live_o  = live_q;
  assign cnt_o   = cnt_q;
  assign state_o = state_q;
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank #(
  parameter int              REG_N    = 32,
  parameter int              REG_W    = 16,
  parameter int              ADDR_W   = 5,
  parameter int              ID_A_IDX = 2,
  parameter logic [REG_W-1:0] ID_A_VAL = 16'h0022,
  parameter int              ID_B_IDX = 3,
  parameter logic [REG_W-1:0] ID_B_VAL = 16'h161A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i
);
  logic [REG_W-1:0] mem_q [REG_N];

  function automatic logic [REG_W-1:0] init_val(int idx);
    if (idx == ID_A_IDX) return ID_A_VAL;
    if (idx == ID_B_IDX) return ID_B_VAL;
    return '0;
  endfunction

  function automatic logic is_ro(int idx);
    return (idx == ID_A_IDX) || (idx == ID_B_IDX);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_N; i++) mem_q[i] <= init_val(i);
    end else begin
      for (int i = 0; i < REG_N; i++)
        if (wr_en_i && wr_addr_i == ADDR_W'(i) && !is_ro(i)) mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mgmt_resp.sv
module mgmt_resp import mgmt_resp_pkg::*; #(
  parameter int               SYNC_LEN = 32,
  parameter int               REG_W    = 16,
  parameter int               REG_N    = 32,
  parameter int               ID_A_IDX = 2,
  parameter logic [REG_W-1:0] ID_A_VAL = 16'h0022,
  parameter int               ID_B_IDX = 3,
  parameter logic [REG_W-1:0] ID_B_VAL = 16'h161A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mgmt_clk_i,
  input  logic mgmt_dout_i,
  input  logic mgmt_oe_i,
  output logic mgmt_din_o
);
  localparam int ADDR_W = $clog2(REG_N);
  localparam int CNT_W  = $clog2(SYNC_LEN + 1);

  logic              rise_w, bit_w, wr_en_w, live_w;
  logic [ADDR_W-1:0] rd_addr_w, wr_addr_w;
  logic [REG_W-1:0]  rd_data_w, wr_data_w;
  logic [CNT_W-1:0]  cnt_w;
  xfer_state_e       state_w;

  mgmt_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mgmt_clk_i  (mgmt_clk_i),
    .mgmt_dout_i (mgmt_dout_i),
    .mgmt_oe_i   (mgmt_oe_i),
    .rise_o      (rise_w),
    .bit_o       (bit_w)
  );

  mgmt_framer #(.SYNC_LEN(SYNC_LEN), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise_w),
    .bit_i     (bit_w),
    .rd_data_i (rd_data_w),
    .rd_addr_o (rd_addr_w),
    .wr_en_o   (wr_en_w),
    .wr_addr_o (wr_addr_w),
    .wr_data_o (wr_data_w),
    .din_o     (mgmt_din_o),
    .live_o    (live_w),
    .cnt_o     (cnt_w),
    .state_o   (state_w)
  );

  mgmt_regbank #(
    .REG_N(REG_N), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .ID_A_IDX(ID_A_IDX), .ID_A_VAL(ID_A_VAL),
    .ID_B_IDX(ID_B_IDX), .ID_B_VAL(ID_B_VAL)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr_w),
    .rd_data_o (rd_data_w),
    .wr_en_i   (wr_en_w),
    .wr_addr_i (wr_addr_w),
    .wr_data_i (wr_data_w)
  );
endmodule

// File: rtl/mgmt_resp_chk.sv
module mgmt_resp_chk import mgmt_resp_pkg::*; #(
  parameter int SYNC_LEN = 32,
  parameter int CNT_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mgmt_din_o,
  input logic             rise_w,
  input logic             live_w,
  input logic [CNT_W-1:0] cnt_w,
  input xfer_state_e      state_w,
  input logic             wr_en_w
);
  // R5: return line moves only on a detected management clock rise
  a_r5_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_w |=> $stable(mgmt_din_o));

  // R9: line holds unless a read is in progress
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w != ST_READ) |=> $stable(mgmt_din_o));

  // R3: arming loads the full sync length, then one bit is consumed
  a_r3_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(live_w) |-> (cnt_w == CNT_W'(SYNC_LEN - 1)));

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_w |-> (cnt_w < CNT_W'(SYNC_LEN)));

  // R4: a transfer state exists only inside an armed frame
  a_r4_active_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w != ST_IDLE) |-> live_w);

  // R4: a committed write closes the frame
  a_r4_write_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_w |=> (state_w == ST_IDLE && !live_w));
endmodule

bind mgmt_resp mgmt_resp_chk #(.SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mgmt_din_o (mgmt_din_o),
  .rise_w     (rise_w),
  .live_w     (live_w),
  .cnt_w      (cnt_w),
  .state_w    (state_w),
  .wr_en_w    (wr_en_w)
);

// File: tb/mgmt_resp_test.sv
`timescale 1ns/1ps
module mgmt_resp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0, mdout = 1'b0, moe = 1'b0;
  logic din;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_mem [32];

  always #10 clk = ~clk;

  mgmt_resp uut (
    .clk_i(clk), .rst_ni(rst_n), .mgmt_clk_i(mclk),
    .mgmt_dout_i(mdout), .mgmt_oe_i(moe), .mgmt_din_o(din)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one management clock period; sample one system clock after the rise
  task automatic mbit(input logic d, input logic oe, output logic smp);
    @(negedge clk); mdout = d; moe = oe; mclk = 1'b0;
    @(negedge clk); mclk = 1'b1;
    @(negedge clk); smp = din;
    @(negedge clk);
  endtask

  function automatic logic [15:0] mk_hdr(logic [1:0] st, logic [1:0] op, logic [4:0] phy,
                                          logic [4:0] rg, logic [1:0] ta);
    return {st, op, phy, rg, ta};
  endfunction

  // rbits: the 16 samples after the header; held: every sample equal to the pre-frame line
  task automatic frame(input int pre_n, input logic pre_oe, input logic [15:0] hdr,
                       input logic ta_oe, input logic data_oe, input logic [15:0] wdata,
                       output logic [15:0] rbits, output logic held);
    logic s, start_v;
    start_v = din;
    held = 1'b1;
    rbits = '0;
    for (int i = 0; i < pre_n; i++) begin mbit(1'b1, pre_oe, s); if (s !== start_v) held = 1'b0; end
    for (int i = 15; i >= 0; i--) begin
      mbit(hdr[i], (i < 2) ? ta_oe : 1'b1, s);
      if (s !== start_v) held = 1'b0;
    end
    for (int i = 15; i >= 0; i--) begin
      mbit(wdata[i], data_oe, s);
      rbits[i] = s;
      if (s !== start_v) held = 1'b0;
    end
    for (int i = 0; i < 2; i++) begin mbit(1'b0, 1'b0, s); if (s !== start_v) held = 1'b0; end
  endtask

  function automatic logic ro(int r);
    return (r == 2) || (r == 3);
  endfunction

  task automatic wr(input int r, input int phy, input logic [15:0] d, output logic held);
    logic [15:0] rb;
    frame(32, 1'b1, mk_hdr(2'b01, 2'b01, 5'(phy), 5'(r), 2'b10), 1'b1, 1'b1, d, rb, held);
    if (!ro(r)) exp_mem[r] = d;
  endtask

  task automatic rd(input int r, input int phy, output logic [15:0] v);
    logic h;
    frame(32, 1'b1, mk_hdr(2'b01, 2'b10, 5'(phy), 5'(r), 2'b00), 1'b0, 1'b0, 16'h0, v, h);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, rb;
    logic h, pre;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) exp_mem[i] = 16'h0;
    exp_mem[2] = 16'h0022; exp_mem[3] = 16'h161A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset line", {15'h0, din}, 16'h0);

    rd(0, 0, v);  chk("R1 reg0", v, 16'h0000);
    rd(2, 1, v);  chk("R1 reg2", v, 16'h0022);
    rd(3, 30, v); chk("R1 reg3", v, 16'h161A);
    rd(31, 0, v); chk("R1 reg31", v, 16'h0000);

    wr(5, 0, 16'hA5C3, h); rd(5, 0, v); chk("R4 write/R5 read", v, 16'hA5C3);
    wr(31, 0, 16'h8001, h); rd(31, 0, v); chk("R5 msb first", v, 16'h8001);

    wr(2, 0, 16'hFFFF, h); rd(2, 0, v); chk("R7 reg2 ro", v, 16'h0022);
    wr(3, 0, 16'h0000, h); rd(3, 0, v); chk("R7 reg3 ro", v, 16'h161A);

    // R6 bad headers
    frame(32, 1'b1, mk_hdr(2'b01, 2'b01, 5'd0, 5'd6, 2'b11), 1'b1, 1'b1, 16'h1234, rb, h);
    frame(32, 1'b1, mk_hdr(2'b01, 2'b11, 5'd0, 5'd6, 2'b10), 1'b1, 1'b1, 16'h1234, rb, h);
    frame(32, 1'b1, mk_hdr(2'b00, 2'b01, 5'd0, 5'd6, 2'b10), 1'b1, 1'b1, 16'h1234, rb, h);
    rd(6, 0, v); chk("R6 bad writes ignored", v, 16'h0000);

    rd(5, 0, v);  // line ends at 1 (LSB of A5C3)
    pre = din;
    frame(32, 1'b1, mk_hdr(2'b11, 2'b10, 5'd0, 5'd5, 2'b00), 1'b0, 1'b0, 16'h0, rb, h);
    chk("R6 bad read holds", {15'h0, h}, 16'h1);
    chk("R6 line value", {15'h0, din}, {15'h0, pre});

    wr(9, 17, 16'h0F0F, h);
    chk("R9 hold during write", {15'h0, h}, 16'h1);
    rd(9, 4, v); chk("R8 phy ignored", v, 16'h0F0F);

    // R3 sync length
    frame(31, 1'b1, mk_hdr(2'b01, 2'b01, 5'd0, 5'd7, 2'b10), 1'b1, 1'b1, 16'hBEEF, rb, h);
    rd(7, 0, v); chk("R3 31 ones ignored", v, 16'h0000);
    frame(40, 1'b1, mk_hdr(2'b01, 2'b01, 5'd0, 5'd7, 2'b10), 1'b1, 1'b1, 16'h1357, rb, h);
    exp_mem[7] = 16'h1357;
    rd(7, 0, v); chk("R3 long sync", v, 16'h1357);

    // R2 output-enable qualifies the line
    frame(32, 1'b0, mk_hdr(2'b01, 2'b01, 5'd0, 5'd8, 2'b10), 1'b1, 1'b1, 16'h7777, rb, h);
    rd(8, 0, v); chk("R2 oe low sync", v, 16'h0000);

    // random mix against the bench model
    for (int k = 0; k < 40; k++) begin
      int r, phy, kind;
      logic [15:0] d;
      r = int'($urandom_range(31)); phy = int'($urandom_range(31));
      kind = int'($urandom_range(2)); d = 16'($urandom);
      if (kind == 0) wr(r, phy, d, h);
      else if (kind == 1) begin rd(r, phy, v); chk("R4 R8 random read", v, exp_mem[r]); end
      else begin
        frame(32, 1'b1, mk_hdr(2'b01, 2'b01, 5'(phy), 5'(r), 2'b00), 1'b1, 1'b1, d, rb, h);
        chk("R6 random bad ta", {15'h0, h}, 16'h1);
      end
    end
    for (int i = 0; i < 32; i++) begin
      rd(i, i, v); chk("R4 R7 final bank", v, exp_mem[i]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule